// File: doc/BRIEF.md
# NAND Flash Bus Interface Front End

This block is the device-side front end of an asynchronous NAND flash bus. A host drives chip enable, a command latch enable, an address latch enable, a write strobe, a read strobe and an 8- or 16-bit I/O bus. All of these are brought into the system clock domain and edge-detected. Each rising edge of the write strobe routes the bus to the command register, the address registers or the page buffer, depending on the two latch enables. Each falling edge of the read strobe returns the page-buffer word at the current column and advances the column.

The block also runs a small operation sequencer. A setup command arms an operation, address bytes select a column and a block, and a matching confirm command starts a busy window of `BUSY_CYC` clocks, shown on the ready output. A write-protect input and a lock-mode input gate program and erase. In lock mode each block carries a lock bit, which commands can set or clear, and write-protect low forces all of them set. The flash array, the charge pumps and the electrical timing lie outside this block. An accepted erase fills the page buffer with ones.

Command codes (low byte): `0x80` program setup, `0x10` program confirm, `0x60` erase setup, `0xD0` erase confirm, `0x00` read setup, `0x30` read confirm, `0x23` unlock setup, `0x2A` lock all. Latch-enable decode {cle, ale}: `10` command, `01` address, `00` data, `11` illegal.

Top module: `nand_fe`

## Requirements
- R1: With ce_n low, cle high and ale low, a write-strobe rising edge captures io_in[7:0] as a command using the codes listed above. io_in[15:8] has no effect on commands.
- R2: With ce_n low, ale high and cle low, the first address byte after a command sets the column to io_in[COL_W-1:0]. The second sets the block to io_in[BLK_W-1:0]. Later address bytes and io_in[15:8] are ignored.
- R3: With ce_n low and both latch enables low, a write-strobe rising edge stores the full io_in word in the page buffer at the column and then increments the column, wrapping from the last column to column 0.
- R4: With ce_n low and the block ready, a read-strobe falling edge drives the page-buffer word at the column onto io_out, sets io_oe and increments the column. io_oe clears when the read strobe rises.
- R5: io_oe is low after reset and whenever ce_n is high.
- R6: A confirm command that matches the armed setup drives rdy low for exactly BUSY_CYC clocks. A confirm with no matching setup is ignored and rdy stays high.
- R7: While rdy is low, raising ce_n neither shortens the busy window nor disturbs the column.
- R8: Raising ce_n while rdy is high puts the block in standby and discards any armed setup.
- R9: With wp_n low, program and erase confirms are rejected: rdy stays high and the page buffer is unchanged. Read operations are unaffected.
- R10: With lock_en high, all blocks are locked after reset. A program or erase confirm aimed at a locked block is rejected. Command 0x23 followed by two address bytes unlocks the block named by the second byte. Command 0x2A locks every block.
- R11: With lock_en high, wp_n low forces every block into the locked state.
- R12: With lock_en low, no block counts as locked.
- R13: A write strobe with cle and ale both high is ignored and leaves any armed setup in place.
- R14: An accepted erase confirm sets every page-buffer word to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latched on its rising edge |
| re_n | input | 1 | Read strobe, reads on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| lock_en | input | 1 | Block lock mode enable |
| io_in | input | DATA_W | I/O bus, input side |
| io_out | output | DATA_W | I/O bus, output side |
| io_oe | output | 1 | I/O output enable (low means bus released) |
| rdy | output | 1 | Ready (high) / busy (low) |

## Verification
Every strobe or level change at the pins acts on the third rising clock edge after it: two synchroniser stages, then the edge detector feeding the capture logic. The rdy output therefore falls on that third edge after a confirm and stays low for exactly BUSY_CYC clocks, and io_out and io_oe settle three edges after the read strobe falls. The bench holds every strobe phase for at least four clocks and samples five clocks after each edge, on the falling clock edge. It measures each busy window by counting low samples of rdy, so both the length of a window and its absence after a rejected confirm are checked directly at the pins.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PROG,
    OP_ERASE,
    OP_READ,
    OP_UNLOCK
  } op_e;

  typedef enum logic [1:0] {
    CYC_DATA = 2'b00,
    CYC_ADDR = 2'b01,
    CYC_CMD  = 2'b10,
    CYC_BAD  = 2'b11
  } cyc_e;

  localparam logic [7:0] CMD_READ_SETUP  = 8'h00;
  localparam logic [7:0] CMD_READ_GO     = 8'h30;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_UNLOCK      = 8'h23;
  localparam logic [7:0] CMD_LOCK_ALL    = 8'h2A;

endpackage

// File: rtl/nfe_sync.sv
module nfe_sync #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/nfe_pbuf.sv
module nfe_pbuf #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              fill,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << COL_W;

  // Storage: no reset, contents are defined by writes or an erase fill.
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wsel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_wsel
    assign wsel[i] = wr_en && (col == COL_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (fill) begin
        mem[i] <= '1;
      end else if (wsel[i]) begin
        mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[col];

endmodule

// File: rtl/nfe_lock.sv
module nfe_lock #(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_mode,
  input  logic             wp_n,
  input  logic             lock_all,
  input  logic             unlock_hit,
  input  logic [BLK_W-1:0] unlock_blk,
  input  logic [BLK_W-1:0] sel_blk,
  output logic             locked
);

  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] lock_vec;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic bit_q;
    logic bit_d;

    always_comb begin
      bit_d = bit_q;
      if (lock_mode && (!wp_n || lock_all)) begin
        bit_d = 1'b1;
      end else if (lock_mode && unlock_hit && (unlock_blk == BLK_W'(b))) begin
        bit_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b1;
      end else begin
        bit_q <= bit_d;
      end
    end

    assign lock_vec[b] = bit_q;
  end

  assign locked = lock_mode & lock_vec[sel_blk];

endmodule

// File: rtl/nfe_ctrl.sv
module nfe_ctrl
  import nfe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int COL_W    = 4,
  parameter int BLK_W    = 3,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              wp_n,
  input  logic [DATA_W-1:0] io_data,
  input  logic              we_rise,
  input  logic              re_fall,
  input  logic              re_rise,
  input  logic              blk_locked,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [COL_W-1:0]  col,
  output logic [BLK_W-1:0]  blk,
  output logic              wr_en,
  output logic              fill,
  output logic              unlock_hit,
  output logic [BLK_W-1:0]  unlock_blk,
  output logic              lock_all,
  output logic [DATA_W-1:0] io_q,
  output logic              oe_q
);

  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

  op_e               op_q, op_d;
  logic [1:0]        acnt_q, acnt_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] io_d;
  logic              oe_d;
  logic [7:0]        cmd;
  logic              pe_ok;

  assign busy       = (cnt_q != '0);
  assign cmd        = io_data[7:0];
  assign unlock_blk = io_data[BLK_W-1:0];
  assign pe_ok      = wp_n && !blk_locked;

  always_comb begin
    op_d       = op_q;
    acnt_d     = acnt_q;
    col_d      = col_q;
    blk_d      = blk_q;
    io_d       = io_q;
    oe_d       = oe_q;
    cnt_d      = busy ? (cnt_q - CNT_W'(1)) : cnt_q;
    wr_en      = 1'b0;
    fill       = 1'b0;
    unlock_hit = 1'b0;
    lock_all   = 1'b0;

    if (re_rise || ce_n) begin
      oe_d = 1'b0;
    end

    if (!busy) begin
      if (ce_n) begin
        op_d   = OP_NONE;
        acnt_d = 2'd0;
      end else if (we_rise) begin
        case (cyc_e'({cle, ale}))
          CYC_CMD: begin
            acnt_d = 2'd0;
            op_d   = OP_NONE;
            case (cmd)
              CMD_READ_SETUP:  op_d = OP_READ;
              CMD_PROG_SETUP:  op_d = OP_PROG;
              CMD_ERASE_SETUP: op_d = OP_ERASE;
              CMD_UNLOCK:      op_d = OP_UNLOCK;
              CMD_LOCK_ALL:    lock_all = 1'b1;
              CMD_PROG_GO: begin
                if (op_q == OP_PROG && pe_ok) begin
                  cnt_d = CNT_LOAD;
                end
              end
              CMD_ERASE_GO: begin
                if (op_q == OP_ERASE && pe_ok) begin
                  cnt_d = CNT_LOAD;
                  fill  = 1'b1;
                end
              end
              CMD_READ_GO: begin
                if (op_q == OP_READ) begin
                  cnt_d = CNT_LOAD;
                end
              end
              default: ;
            endcase
          end
          CYC_ADDR: begin
            if (acnt_q == 2'd0) begin
              col_d = io_data[COL_W-1:0];
            end else if (acnt_q == 2'd1) begin
              blk_d      = io_data[BLK_W-1:0];
              unlock_hit = (op_q == OP_UNLOCK);
            end
            if (acnt_q != 2'd2) begin
              acnt_d = acnt_q + 2'd1;
            end
          end
          CYC_DATA: begin
            wr_en = 1'b1;
            col_d = col_q + COL_W'(1);
          end
          default: ;
        endcase
      end else if (re_fall) begin
        io_d  = rd_data;
        oe_d  = 1'b1;
        col_d = col_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      acnt_q <= 2'd0;
      col_q  <= '0;
      blk_q  <= '0;
      cnt_q  <= '0;
      io_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      op_q   <= op_d;
      acnt_q <= acnt_d;
      col_q  <= col_d;
      blk_q  <= blk_d;
      cnt_q  <= cnt_d;
      io_q   <= io_d;
      oe_q   <= oe_d;
    end
  end

  assign col = col_q;
  assign blk = blk_q;

endmodule

// File: rtl/nand_fe.sv
module nand_fe #(
  parameter int DATA_W   = 16,
  parameter int COL_W    = 4,
  parameter int BLK_W    = 3,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_n,
  input  logic              re_n,
  input  logic              wp_n,
  input  logic              lock_en,
  input  logic [DATA_W-1:0] io_in,
  output logic [DATA_W-1:0] io_out,
  output logic              io_oe,
  output logic              rdy
);

  localparam int SW = DATA_W + 7;
  // Idle levels: lock_en 0, wp_n 1, re_n 1, we_n 1, ale 0, cle 0, ce_n 1.
  localparam logic [SW-1:0] SYNC_RST = {7'b0111001, {DATA_W{1'b0}}};

  logic              rst_m_q;
  logic              rst_s_n;
  logic [SW-1:0]     sync_q;
  logic              lock_en_s, wp_n_s, re_s, we_s, ale_s, cle_s, ce_n_s;
  logic [DATA_W-1:0] io_s;
  logic              we_p, re_p;
  logic              we_rise, re_fall, re_rise;
  logic              busy, wr_en, fill, unlock_hit, lock_all, blk_locked, oe_q;
  logic [COL_W-1:0]  col;
  logic [BLK_W-1:0]  blk, unlock_blk;
  logic [DATA_W-1:0] rd_data, io_q;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  nfe_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     ({lock_en, wp_n, re_n, we_n, ale, cle, ce_n, io_in}),
    .q     (sync_q)
  );

  assign {lock_en_s, wp_n_s, re_s, we_s, ale_s, cle_s, ce_n_s, io_s} = sync_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      we_p <= 1'b1;
      re_p <= 1'b1;
    end else begin
      we_p <= we_s;
      re_p <= re_s;
    end
  end

  assign we_rise = we_s & ~we_p;
  assign re_fall = ~re_s & re_p;
  assign re_rise = re_s & ~re_p;

  nfe_ctrl #(
    .DATA_W   (DATA_W),
    .COL_W    (COL_W),
    .BLK_W    (BLK_W),
    .BUSY_CYC (BUSY_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ce_n       (ce_n_s),
    .cle        (cle_s),
    .ale        (ale_s),
    .wp_n       (wp_n_s),
    .io_data    (io_s),
    .we_rise    (we_rise),
    .re_fall    (re_fall),
    .re_rise    (re_rise),
    .blk_locked (blk_locked),
    .rd_data    (rd_data),
    .busy       (busy),
    .col        (col),
    .blk        (blk),
    .wr_en      (wr_en),
    .fill       (fill),
    .unlock_hit (unlock_hit),
    .unlock_blk (unlock_blk),
    .lock_all   (lock_all),
    .io_q       (io_q),
    .oe_q       (oe_q)
  );

  nfe_pbuf #(.DATA_W(DATA_W), .COL_W(COL_W)) u_pbuf (
    .clk     (clk),
    .wr_en   (wr_en),
    .fill    (fill),
    .col     (col),
    .wr_data (io_s),
    .rd_data (rd_data)
  );

  nfe_lock #(.BLK_W(BLK_W)) u_lock (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .lock_mode  (lock_en_s),
    .wp_n       (wp_n_s),
    .lock_all   (lock_all),
    .unlock_hit (unlock_hit),
    .unlock_blk (unlock_blk),
    .sel_blk    (blk),
    .locked     (blk_locked)
  );

  assign io_out = io_q;
  assign io_oe  = oe_q;
  assign rdy    = ~busy;

endmodule

// File: rtl/nand_fe_chk.sv
module nand_fe_chk #(
  parameter int COL_W    = 4,
  parameter int BUSY_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n_s,
  input logic             wp_n_s,
  input logic             lock_en_s,
  input logic             we_rise,
  input logic             re_fall,
  input logic             busy,
  input logic [COL_W-1:0] col,
  input logic             io_oe,
  input logic             blk_locked
);

  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!busy) begin
      run_q <= '0;
    end else if (run_q != 16'hFFFF) begin
      run_q <= run_q + 16'd1;
    end
  end

  // R6: every busy window is exactly BUSY_CYC clocks long
  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (run_q == 16'(BUSY_CYC)));

  // R6: busy only starts from a captured write strobe
  a_r6_busy_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we_rise));

  // R5: deselected chip releases the bus
  a_r5_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_s |=> !io_oe);

  // R4: the bus is driven only after a read strobe fall
  a_r4_oe_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe) |-> $past(re_fall));

  // R7: the column holds while busy
  a_r7_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(col));

  // R11: write-protect in lock mode locks the selected block
  a_r11_force_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wp_n_s && lock_en_s) && lock_en_s) |-> blk_locked);

endmodule

bind nand_fe nand_fe_chk #(.COL_W(COL_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .ce_n_s     (ce_n_s),
  .wp_n_s     (wp_n_s),
  .lock_en_s  (lock_en_s),
  .we_rise    (we_rise),
  .re_fall    (re_fall),
  .busy       (busy),
  .col        (col),
  .io_oe      (io_oe),
  .blk_locked (blk_locked)
);

// File: tb/nand_fe_bench.sv
module nand_fe_bench;

  localparam int DW   = 16;
  localparam int BUSY = 8;
  localparam int NVEC = 14;
  // Vector: [33:32] kind (0 cmd, 1 addr, 2 data, 3 read+check), [31:16] bus, [15:0] expected
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 16'hAB80, 16'h0000},
    {2'd1, 16'h5502, 16'h0000},
    {2'd1, 16'h6601, 16'h0000},
    {2'd2, 16'h1234, 16'h0000},
    {2'd2, 16'hBEEF, 16'h0000},
    {2'd2, 16'h00FF, 16'h0000},
    {2'd0, 16'hC710, 16'h0000},
    {2'd0, 16'h9900, 16'h0000},
    {2'd1, 16'h00F2, 16'h0000},
    {2'd1, 16'h0001, 16'h0000},
    {2'd0, 16'h0030, 16'h0000},
    {2'd3, 16'h0000, 16'h1234},
    {2'd3, 16'h0000, 16'hBEEF},
    {2'd3, 16'h0000, 16'h00FF}
  };

  logic clk = 1'b0;
  logic rst_n, ce_n, cle, ale, we_n, re_n, wp_n, lock_en;
  logic [DW-1:0] io_in, io_out;
  logic io_oe, rdy;

  int n_chk = 0;
  int n_fail = 0;
  int run = 0;
  int last_run = 0;
  int n_runs = 0;

  always #2 clk = ~clk;

  nand_fe #(.DATA_W(DW), .COL_W(4), .BLK_W(3), .BUSY_CYC(BUSY)) u_nand_fe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .lock_en(lock_en), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rdy(rdy)
  );

  always @(negedge clk) begin
    if (rst_n && !rdy) begin
      if (run == 0) n_runs = n_runs + 1;
      run = run + 1;
    end else if (run != 0) begin
      last_run = run;
      run = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    cle = c; ale = a; io_in = d; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd(output logic [DW-1:0] d, output logic oe);
    @(negedge clk);
    re_n = 1'b0;
    repeat (5) @(negedge clk);
    d = io_out; oe = io_oe;
    re_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_ready();
    int k = 0;
    while (!rdy && k < 1000) begin
      @(negedge clk);
      k++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] col, input logic [7:0] blk);
    wr(1'b1, 1'b0, {8'h00, c});
    wr(1'b0, 1'b1, {8'h00, col});
    wr(1'b0, 1'b1, {8'h00, blk});
  endtask

  task automatic confirm(input logic [7:0] c, input bit accept, input string tag);
    int n0 = n_runs;
    wr(1'b1, 1'b0, {8'h00, c});
    wait_ready();
    chk(tag, n_runs - n0, accept ? 1 : 0);
    if (accept) chk(tag, last_run, BUSY);
  endtask

  task automatic read_page(input logic [7:0] col, input logic [7:0] blk);
    setup(8'h00, col, blk);
    confirm(8'h30, 1'b1, "R6 read busy");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic oe;
    int n0;
    rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1;
    wp_n = 1'b1; lock_en = 1'b0; io_in = '0;
    repeat (5) @(negedge clk);
    chk("R5 reset oe", io_oe, 0);
    chk("R6 reset rdy", rdy, 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    ce_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 idle oe", io_oe, 0);

    // Vector walk: program three words, read them back (R1 R2 R3 R4)
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][33:32])
        2'd0: begin wr(1'b1, 1'b0, VEC[i][31:16]); wait_ready(); end
        2'd1: wr(1'b0, 1'b1, VEC[i][31:16]);
        2'd2: wr(1'b0, 1'b0, VEC[i][31:16]);
        default: begin
          rd(d, oe);
          chk("R1 R2 R3 R4 vector data", d, VEC[i][15:0]);
          chk("R4 vector oe", oe, 1);
        end
      endcase
    end
    chk("R4 oe released after re rise", io_oe, 0);

    // R6: busy length and unmatched confirm
    read_page(8'h00, 8'h01);
    n0 = n_runs;
    wr(1'b1, 1'b0, 16'h0010);
    wait_ready();
    chk("R6 unmatched confirm ignored", n_runs - n0, 0);

    // R7: ce_n high during busy does not shorten it
    setup(8'h00, 8'h00, 8'h01);
    wr(1'b1, 1'b0, 16'h0030);
    ce_n = 1'b1;
    wait_ready();
    chk("R7 busy full length with ce_n high", last_run, BUSY);
    chk("R5 oe low while deselected", io_oe, 0);
    ce_n = 1'b0;
    repeat (6) @(negedge clk);

    // R8: standby discards armed setup
    setup(8'h80, 8'h00, 8'h01);
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
    ce_n = 1'b0;
    repeat (6) @(negedge clk);
    confirm(8'h10, 1'b0, "R8 standby drops setup");

    // R9: write protect rejects program and erase, read still works
    wp_n = 1'b0;
    repeat (6) @(negedge clk);
    setup(8'h80, 8'h00, 8'h01);
    confirm(8'h10, 1'b0, "R9 program rejected");
    setup(8'h60, 8'h00, 8'h01);
    confirm(8'hD0, 1'b0, "R9 erase rejected");
    read_page(8'h02, 8'h01);
    rd(d, oe);
    chk("R9 page kept after rejected erase", d, 16'h1234);
    wp_n = 1'b1;
    repeat (6) @(negedge clk);

    // R13: both latch enables high ignored, setup stays armed
    setup(8'h80, 8'h00, 8'h01);
    n0 = n_runs;
    wr(1'b1, 1'b1, 16'h0010);
    repeat (4) @(negedge clk);
    chk("R13 illegal cycle ignored", n_runs - n0, 0);
    confirm(8'h10, 1'b1, "R13 setup still armed");

    // R14: accepted erase fills page with ones
    setup(8'h60, 8'h00, 8'h01);
    confirm(8'hD0, 1'b1, "R14 erase accepted");
    read_page(8'h05, 8'h01);
    rd(d, oe);
    chk("R14 erased word", d, 16'hFFFF);

    // R3: column wrap
    setup(8'h80, 8'h0F, 8'h01);
    wr(1'b0, 1'b0, 16'hAAAA);
    wr(1'b0, 1'b0, 16'h5555);
    confirm(8'h10, 1'b1, "R6 program busy");
    read_page(8'h0F, 8'h01);
    rd(d, oe);
    chk("R3 last column", d, 16'hAAAA);
    rd(d, oe);
    chk("R3 wrapped to column 0", d, 16'h5555);

    // R5: deselect during read releases bus
    @(negedge clk);
    re_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 oe during read", io_oe, 1);
    ce_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 oe off on deselect", io_oe, 0);
    re_n = 1'b1;
    ce_n = 1'b0;
    repeat (6) @(negedge clk);

    // R10: lock mode
    lock_en = 1'b1;
    repeat (6) @(negedge clk);
    setup(8'h80, 8'h00, 8'h03);
    confirm(8'h10, 1'b0, "R10 program locked block");
    setup(8'h60, 8'h00, 8'h03);
    confirm(8'hD0, 1'b0, "R10 erase locked block");
    setup(8'h23, 8'h00, 8'h03);
    setup(8'h80, 8'h00, 8'h03);
    confirm(8'h10, 1'b1, "R10 program unlocked block");
    setup(8'h80, 8'h00, 8'h02);
    confirm(8'h10, 1'b0, "R10 other block still locked");

    // R11: write protect in lock mode relocks all
    wp_n = 1'b0;
    repeat (6) @(negedge clk);
    wp_n = 1'b1;
    repeat (6) @(negedge clk);
    setup(8'h80, 8'h00, 8'h03);
    confirm(8'h10, 1'b0, "R11 relocked by write protect");

    // R10: lock-all command
    setup(8'h23, 8'h00, 8'h03);
    wr(1'b1, 1'b0, 16'h002A);
    setup(8'h80, 8'h00, 8'h03);
    confirm(8'h10, 1'b0, "R10 lock all command");

    // R12: lock mode off, nothing locked
    lock_en = 1'b0;
    repeat (6) @(negedge clk);
    setup(8'h80, 8'h00, 8'h02);
    confirm(8'h10, 1'b1, "R12 lock mode disabled");

    summary();
    $finish;
  end

endmodule